// File: doc/BRIEF.md
# Time-Multiplexed Two-Variable Spiking Neuron Core

This block advances a small population of spiking neurons by one forward-Euler time step each time it receives a step strobe. Every neuron carries two signed fixed-point state variables, a membrane potential `v` and a slow recovery variable `n`, held in an internal register file. One shared datapath evaluates the two piecewise-quadratic nullclines and the Euler update for one neuron per clock, in index order. All constants are powers of two or short sums of them, so every scaling is a shift. The only true products are the squares inside the nullclines.

A host supplies one stimulus current per neuron on a flat bus. It raises `step_i` once per model time step and collects one result per cycle: the new `v` and `n`, the neuron index, and a spike flag. A one-cycle `done_o` marks the last result of the pass. A single mode bit selects between two parameter sets. Class I gives a full-step potential update. Class II halves the potential update and uses its own bias, threshold and slow-nullcline constants.

Top module: `tmn_neuron_core`

## Requirements
- R1: While `rst_ni` is low and after its release, all outputs are zero. Every neuron's state is set to v = -0.75 (raw -3·2^(FRAC-2)) and n = 0.
- R2: When `step_i` is high at a clock edge while the core is idle, a pass starts. After the (k+1)-th following edge, `out_valid_o` is high with `out_idx_o` = k, for k = 0 .. NEURONS-1, one neuron per cycle.
- R3: `done_o` is high for exactly one cycle, together with the result for index NEURONS-1. `out_valid_o` is low in the cycle after it unless a new pass had been started.
- R4: `step_i` during a pass has no effect. The pass runs on without restart, and no extra results appear once it ends.
- R5: `mode_i` is sampled at the edge that starts a pass (0 = Class I, 1 = Class II). Changing it during the pass does not alter that pass.
- R6: The fast nullcline is f(v) = 8(v+1/4)^2 - 1/2 for v < 0, and f(v) = 1/2 - 8(v-1/4)^2 for v >= 0.
- R7: The slow nullcline is g(v) = kn(v+1/4)^2 + qn for v < r, and g(v) = 16(v+1/4)^2 - 11/16 otherwise. Class I uses kn = 2, qn = -9/16, r = -13/64. Class II uses kn = 4, qn = -3/4, r = -15/64.
- R8: All values are two's complement with FRAC fraction bits, and each square is floor(x·x / 2^FRAC). The update is v' = v + floor((f - n + I0 + stim) / 2^(DT_SHIFT+p)) and n' = n + floor((g - n) / 2^DT_SHIFT). Class I uses I0 = 31/512 and p = 0. Class II uses I0 = 1/32 and p = 1. Both results are clipped to the W-bit range.
- R9: `spike_o` is high with a result exactly when that neuron's v was negative before the step and is zero or positive after it.
- R10: Neuron k takes its stimulus from `stim_i[k*W +: W]`, which is sampled in the cycle that neuron is processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Start one Euler pass over all neurons |
| mode_i | input | 1 | Parameter set: 0 Class I, 1 Class II |
| stim_i | input | NEURONS*W | Per-neuron stimulus currents, neuron k at bits k*W+W-1:k*W |
| out_valid_o | output | 1 | A neuron result is present |
| out_idx_o | output | $clog2(NEURONS) | Index of the neuron being reported |
| v_o | output | W | Updated membrane potential |
| n_o | output | W | Updated slow variable |
| spike_o | output | 1 | Zero crossing of v in this step |
| done_o | output | 1 | Last neuron of the pass reported |

## Verification
The edge that accepts `step_i` only loads the sequencer. The result for neuron k is registered at the (k+1)-th edge after it, and `done_o` shares the edge of the last result. The bench therefore releases the strobe one falling edge after raising it. It then samples one result on each following falling edge, where the next clock edge cannot disturb it, and checks every field against a reference model that tracks each neuron's state from reset. One more falling edge after the pass confirms that no result follows. That check catches a restart caused by a strobe issued mid-pass.

// File: rtl/tmn_pkg.sv
package tmn_pkg;
  typedef enum logic {CLS_ONE = 1'b0, CLS_TWO = 1'b1} cls_e;

  // num / 2^sh expressed with frac fraction bits
  function automatic longint fx(input int num, input int sh, input int frac);
    return longint'(num) <<< (frac - sh);
  endfunction
endpackage

// File: rtl/tmn_quad_term.sv
module tmn_quad_term #(
  parameter int W    = 18,
  parameter int WX   = 42,
  parameter int FRAC = 12
) (
  input  logic signed [W-1:0]  v_i,
  input  logic signed [WX-1:0] off_i,
  input  logic        [2:0]    sh_i,
  input  logic signed [WX-1:0] bias_i,
  output logic signed [WX-1:0] term_o
);
  logic signed [WX-1:0]   vx, d, sq;
  logic signed [2*WX-1:0] p;

  always_comb begin
    vx     = v_i;
    d      = vx - off_i;
    p      = d * d;
    sq     = WX'(p >>> FRAC);
    term_o = (sq <<< sh_i) + bias_i;
  end
endmodule

// File: rtl/tmn_nullclines.sv
module tmn_nullclines
  import tmn_pkg::*;
#(
  parameter int W    = 18,
  parameter int WX   = 42,
  parameter int FRAC = 12
) (
  input  logic signed [W-1:0]  v_i,
  input  cls_e                 cls_i,
  output logic signed [WX-1:0] f_o,
  output logic signed [WX-1:0] g_o
);
  localparam logic signed [WX-1:0] C_QTR  = WX'(fx(1, 2, FRAC));
  localparam logic signed [WX-1:0] C_HALF = WX'(fx(1, 1, FRAC));
  localparam logic signed [WX-1:0] C_QP   = WX'(fx(-11, 4, FRAC));
  localparam logic signed [WX-1:0] C_QN1  = WX'(fx(-9, 4, FRAC));
  localparam logic signed [WX-1:0] C_QN2  = WX'(fx(-3, 2, FRAC));
  localparam logic signed [WX-1:0] C_R1   = WX'(fx(-13, 6, FRAC));
  localparam logic signed [WX-1:0] C_R2   = WX'(fx(-15, 6, FRAC));
  localparam int NT = 4;

  logic signed [WX-1:0] off_a  [NT];
  logic        [2:0]    sh_a   [NT];
  logic signed [WX-1:0] bias_a [NT];
  logic signed [WX-1:0] term_a [NT];
  logic signed [WX-1:0] vx, r_c;

  // 0: f below zero, 1: f at/above zero (negated), 2: g below r, 3: g at/above r
  always_comb begin
    off_a[0] = -C_QTR; sh_a[0] = 3'd3; bias_a[0] = -C_HALF;
    off_a[1] =  C_QTR; sh_a[1] = 3'd3; bias_a[1] = -C_HALF;
    off_a[2] = -C_QTR; sh_a[2] = (cls_i == CLS_TWO) ? 3'd2 : 3'd1;
    bias_a[2] = (cls_i == CLS_TWO) ? C_QN2 : C_QN1;
    off_a[3] = -C_QTR; sh_a[3] = 3'd4; bias_a[3] = C_QP;
  end

  for (genvar t = 0; t < NT; t++) begin : g_term
    tmn_quad_term #(.W(W), .WX(WX), .FRAC(FRAC)) u_term (
      .v_i    (v_i),
      .off_i  (off_a[t]),
      .sh_i   (sh_a[t]),
      .bias_i (bias_a[t]),
      .term_o (term_a[t])
    );
  end

  always_comb begin
    vx  = v_i;
    r_c = (cls_i == CLS_TWO) ? C_R2 : C_R1;
    f_o = v_i[W-1] ? term_a[0] : -term_a[1];
    g_o = (vx < r_c) ? term_a[2] : term_a[3];
  end
endmodule

// File: rtl/tmn_euler_step.sv
module tmn_euler_step
  import tmn_pkg::*;
#(
  parameter int W        = 18,
  parameter int WX       = 42,
  parameter int FRAC     = 12,
  parameter int DT_SHIFT = 4
) (
  input  logic signed [W-1:0]  v_i,
  input  logic signed [W-1:0]  n_i,
  input  logic signed [W-1:0]  stim_i,
  input  logic signed [WX-1:0] f_i,
  input  logic signed [WX-1:0] g_i,
  input  cls_e                 cls_i,
  output logic signed [W-1:0]  v_nxt_o,
  output logic signed [W-1:0]  n_nxt_o
);
  localparam logic signed [WX-1:0] C_I01 = WX'(fx(31, 9, FRAC));
  localparam logic signed [WX-1:0] C_I02 = WX'(fx(1, 5, FRAC));
  localparam logic signed [WX-1:0] S_MAX = WX'((longint'(1) <<< (W-1)) - 1);
  localparam logic signed [WX-1:0] S_MIN = -S_MAX - 1;

  logic signed [WX-1:0] vx, nx, sx, dv_sum, dv, dn, v_sum, n_sum;

  always_comb begin
    vx     = v_i;
    nx     = n_i;
    sx     = stim_i;
    dv_sum = f_i - nx + sx + ((cls_i == CLS_TWO) ? C_I02 : C_I01);
    // phi = 1/2 in Class II folds into one extra shift
    dv     = (cls_i == CLS_TWO) ? (dv_sum >>> (DT_SHIFT + 1)) : (dv_sum >>> DT_SHIFT);
    dn     = (g_i - nx) >>> DT_SHIFT;
    v_sum  = vx + dv;
    n_sum  = nx + dn;
    v_nxt_o = (v_sum > S_MAX) ? W'(S_MAX) : (v_sum < S_MIN) ? W'(S_MIN) : W'(v_sum);
    n_nxt_o = (n_sum > S_MAX) ? W'(S_MAX) : (n_sum < S_MIN) ? W'(S_MIN) : W'(n_sum);
  end
endmodule

// File: rtl/tmn_neuron_core.sv
module tmn_neuron_core
  import tmn_pkg::*;
#(
  parameter int NEURONS  = 16,
  parameter int W        = 18,
  parameter int FRAC     = 12,
  parameter int DT_SHIFT = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        step_i,
  input  logic                        mode_i,
  input  logic [NEURONS*W-1:0]        stim_i,
  output logic                        out_valid_o,
  output logic [$clog2(NEURONS)-1:0]  out_idx_o,
  output logic signed [W-1:0]         v_o,
  output logic signed [W-1:0]         n_o,
  output logic                        spike_o,
  output logic                        done_o
);
  localparam int IW = $clog2(NEURONS);
  localparam int WX = 2 * W + 6;
  localparam logic [IW-1:0] LAST = IW'(NEURONS - 1);
  localparam logic signed [W-1:0] V_INIT = W'(fx(-3, 2, FRAC));

  logic signed [W-1:0]  v_q [NEURONS];
  logic signed [W-1:0]  n_q [NEURONS];
  logic signed [W-1:0]  stim_a [NEURONS];
  logic                 busy_q;
  logic [IW-1:0]        idx_q;
  cls_e                 cls_q;
  logic signed [W-1:0]  cur_v, cur_n, cur_s, v_nxt, n_nxt;
  logic signed [WX-1:0] f_val, g_val;

  for (genvar k = 0; k < NEURONS; k++) begin : g_stim
    assign stim_a[k] = stim_i[k*W +: W];
  end

  assign cur_v = v_q[idx_q];
  assign cur_n = n_q[idx_q];
  assign cur_s = stim_a[idx_q];

  tmn_nullclines #(.W(W), .WX(WX), .FRAC(FRAC)) u_ncl (
    .v_i   (cur_v),
    .cls_i (cls_q),
    .f_o   (f_val),
    .g_o   (g_val)
  );

  tmn_euler_step #(.W(W), .WX(WX), .FRAC(FRAC), .DT_SHIFT(DT_SHIFT)) u_step (
    .v_i     (cur_v),
    .n_i     (cur_n),
    .stim_i  (cur_s),
    .f_i     (f_val),
    .g_i     (g_val),
    .cls_i   (cls_q),
    .v_nxt_o (v_nxt),
    .n_nxt_o (n_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NEURONS; k++) begin
        v_q[k] <= V_INIT;
        n_q[k] <= '0;
      end
      busy_q      <= 1'b0;
      idx_q       <= '0;
      cls_q       <= CLS_ONE;
      out_valid_o <= 1'b0;
      out_idx_o   <= '0;
      v_o         <= '0;
      n_o         <= '0;
      spike_o     <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      out_valid_o <= 1'b0;
      spike_o     <= 1'b0;
      done_o      <= 1'b0;
      if (!busy_q && step_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        cls_q  <= cls_e'(mode_i);
      end else if (busy_q) begin
        v_q[idx_q]  <= v_nxt;
        n_q[idx_q]  <= n_nxt;
        out_valid_o <= 1'b1;
        out_idx_o   <= idx_q;
        v_o         <= v_nxt;
        n_o         <= n_nxt;
        spike_o     <= cur_v[W-1] && !v_nxt[W-1];
        if (idx_q == LAST) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  AST_FIRST_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> out_idx_o == '0); // R2
  AST_IDX_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_idx_o != LAST) |=> (out_valid_o && out_idx_o == $past(out_idx_o) + 1'b1)); // R2
  AST_DONE_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (out_valid_o && out_idx_o == LAST)); // R3
  AST_DONE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !out_valid_o); // R3
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && idx_q != LAST) |=> $stable(cls_q)); // R5
  AST_SPIKE_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spike_o |-> (out_valid_o && !v_o[W-1])); // R9
endmodule

// File: tb/tmn_neuron_core_tb.sv
`timescale 1ns/1ps
module tmn_neuron_core_tb_top;
  localparam int NEURONS  = 16;
  localparam int W        = 18;
  localparam int FRAC     = 12;
  localparam int DT_SHIFT = 4;
  localparam int IW       = $clog2(NEURONS);

  localparam longint QTR  = longint'(1) <<< (FRAC - 2);
  localparam longint HALF = longint'(1) <<< (FRAC - 1);
  localparam longint QP   = -(longint'(11) <<< (FRAC - 4));
  localparam longint QN1  = -(longint'(9) <<< (FRAC - 4));
  localparam longint QN2  = -(longint'(3) <<< (FRAC - 2));
  localparam longint RT1  = -(longint'(13) <<< (FRAC - 6));
  localparam longint RT2  = -(longint'(15) <<< (FRAC - 6));
  localparam longint BI1  = longint'(31) <<< (FRAC - 9);
  localparam longint BI2  = longint'(1) <<< (FRAC - 5);
  localparam longint VMAX = (longint'(1) <<< (W - 1)) - 1;
  localparam longint VMIN = -(longint'(1) <<< (W - 1));

  // mode, stimulus base, stimulus stride per neuron (raw units)
  localparam int NVEC = 6;
  localparam int VEC [NVEC][3] = '{
    '{0,  49152,    0},
    '{0,  -8192, 1024},
    '{1,   4096, -512},
    '{1,      0, 3000},
    '{0, -131072,   0},
    '{1, 131071,    0}
  };

  logic                   clk_i = 1'b0;
  logic                   rst_ni = 1'b0;
  logic                   step_i = 1'b0;
  logic                   mode_i = 1'b0;
  logic [NEURONS*W-1:0]   stim_i = '0;
  logic                   out_valid_o;
  logic [IW-1:0]          out_idx_o;
  logic signed [W-1:0]    v_o;
  logic signed [W-1:0]    n_o;
  logic                   spike_o;
  logic                   done_o;

  int checks = 0;
  int errors = 0;
  longint mv [NEURONS];
  longint mn [NEURONS];

  always #5 clk_i = ~clk_i;

  tmn_neuron_core #(.NEURONS(NEURONS), .W(W), .FRAC(FRAC), .DT_SHIFT(DT_SHIFT)) dut_i (
    .clk_i, .rst_ni, .step_i, .mode_i, .stim_i,
    .out_valid_o, .out_idx_o, .v_o, .n_o, .spike_o, .done_o
  );

  function automatic longint m_sq(input longint x);
    return (x * x) >>> FRAC;
  endfunction

  function automatic longint m_f(input longint v);
    if (v < 0) return (m_sq(v + QTR) <<< 3) - HALF;
    return HALF - (m_sq(v - QTR) <<< 3);
  endfunction

  function automatic longint m_g(input longint v, input bit m);
    longint r = m ? RT2 : RT1;
    if (v < r) return (m_sq(v + QTR) <<< (m ? 2 : 1)) + (m ? QN2 : QN1);
    return (m_sq(v + QTR) <<< 4) + QP;
  endfunction

  function automatic longint m_clip(input longint x);
    if (x > VMAX) return VMAX;
    if (x < VMIN) return VMIN;
    return x;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < NEURONS; k++) begin
      mv[k] = -(longint'(3) <<< (FRAC - 2));
      mn[k] = 0;
    end
  endtask

  // one pass; optional strobe during the pass and mode change after start
  task automatic run_pass(input bit m, input longint base, input longint stride,
                          input string tg, input bit poke_step, input bit flip_mode);
    longint s [NEURONS];
    for (int k = 0; k < NEURONS; k++) begin
      s[k] = base + k * stride;
      stim_i[k*W +: W] = s[k][W-1:0];
    end
    mode_i = m;
    @(negedge clk_i);
    step_i = 1'b1;
    @(negedge clk_i);
    step_i = 1'b0;
    if (flip_mode) mode_i = ~m;
    for (int k = 0; k < NEURONS; k++) begin
      longint ev, en, dv;
      bit     es;
      @(negedge clk_i);
      step_i = poke_step && (k == 3);
      dv = m_f(mv[k]) - mn[k] + (m ? BI2 : BI1) + s[k];
      dv = dv >>> (DT_SHIFT + (m ? 1 : 0));
      ev = m_clip(mv[k] + dv);
      en = m_clip(mn[k] + ((m_g(mv[k], m) - mn[k]) >>> DT_SHIFT));
      es = (mv[k] < 0) && (ev >= 0);
      chk(out_valid_o && out_idx_o == IW'(k), "R2", "valid/index", longint'(out_idx_o), k);
      chk(longint'(v_o) == ev, tg, "v", longint'(v_o), ev);
      chk(longint'(n_o) == en, tg, "n", longint'(n_o), en);
      chk(spike_o == es, "R9", "spike", longint'(spike_o), longint'(es));
      chk(done_o == (k == NEURONS - 1), "R3", "done", longint'(done_o), longint'(k == NEURONS - 1));
      mv[k] = ev;
      mn[k] = en;
    end
    step_i = 1'b0;
    @(negedge clk_i);
    chk(!out_valid_o && !done_o, poke_step ? "R4" : "R3", "quiet after pass",
        longint'(out_valid_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int spikes;
    model_reset();
    repeat (3) @(negedge clk_i);
    chk(!out_valid_o && !done_o && !spike_o && v_o == '0 && n_o == '0 && out_idx_o == '0,
        "R1", "outputs in reset", longint'(out_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!out_valid_o && !done_o && v_o == '0, "R1", "outputs after release",
        longint'(v_o), 0);

    // vector walk: per-vector tag names the requirement stressed most
    for (int i = 0; i < NVEC; i++) begin
      string tg;
      case (i)
        0: tg = "R6";
        1: tg = "R10";
        2, 3: tg = "R7";
        4: tg = "R6";
        default: tg = "R8";
      endcase
      run_pass(VEC[i][0] != 0, VEC[i][1], VEC[i][2], tg, 1'b0, 1'b0);
    end

    // R9: a strong push from the rest state must produce a spike
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    model_reset();
    spikes = 0;
    for (int k = 0; k < NEURONS; k++) stim_i[k*W +: W] = W'(49152);
    mode_i = 1'b0;
    @(negedge clk_i);
    step_i = 1'b1;
    @(negedge clk_i);
    step_i = 1'b0;
    for (int k = 0; k < NEURONS; k++) begin
      @(negedge clk_i);
      if (spike_o) spikes++;
    end
    chk(spikes == NEURONS, "R9", "spike count from rest", spikes, NEURONS);
    for (int k = 0; k < NEURONS; k++) begin
      mv[k] = mv[k] + ((m_f(mv[k]) - mn[k] + BI1 + 49152) >>> DT_SHIFT);
      mn[k] = mn[k] + ((m_g(-(longint'(3) <<< (FRAC - 2)), 1'b0) - 0) >>> DT_SHIFT);
    end
    @(negedge clk_i);

    // R1: reset restores the rest state, seen through a zero-stimulus pass
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    model_reset();
    run_pass(1'b0, 0, 0, "R1", 1'b0, 1'b0);

    // R4: strobe during the pass is ignored
    run_pass(1'b1, 2048, 256, "R4", 1'b1, 1'b0);

    // R5: mode change after start does not affect the pass
    run_pass(1'b1, -4096, 700, "R5", 1'b0, 1'b1);
    run_pass(1'b0, 6000, -300, "R5", 1'b0, 1'b1);

    // R4: idle with no strobe yields no results
    mode_i = 1'b0;
    repeat (5) begin
      @(negedge clk_i);
      chk(!out_valid_o && !done_o, "R4", "idle quiet", longint'(out_valid_o), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule